// File: doc/BRIEF.md
# Serial Packet Output Framer

This block is the transmit stage of one router output port. An upstream source hands it payload bytes over a valid/ready handshake, and a last flag marks the final byte of each packet. The block shifts each byte out one bit per clock. Two active-low strobes go with the bit stream. The frame strobe covers the whole extent of a packet. The qualify strobe marks each clock that carries a real data bit.

The block works on one packet at a time, in the order the bytes arrive. It holds only the byte it is shifting at that moment. If the next byte of an open packet is late, the block inserts stall cycles: the qualify strobe goes high while the frame strobe stays low. On the eighth bit of the last byte the frame strobe rises in the same clock as that bit. When the next packet's first byte is already waiting, that packet can start on the following clock.

Top module: `serial_pkt_framer`

## Requirements
- R1: With no packet open, `ser_data` is 0 and both `ser_valid_n` and `ser_frame_n` are 1.
- R2: `ser_frame_n` goes low with the first qualified bit of a packet and stays low through every bit and every stall cycle of that packet until its end.
- R3: Each byte leaves as exactly 8 qualified bits (clocks with `ser_valid_n` = 0), least significant bit first.
- R4: `ser_frame_n` is 1 together with `ser_valid_n` = 0 only on the eighth qualified bit of the byte accepted with `in_last` = 1. That is the clock where the packet ends.
- R5: Bytes and packet boundaries are delivered in the same order they were accepted, across any number of packets.
- R6: `in_ready` is 1 only when no byte is being shifted or on the clock of the eighth bit. A byte accepted at a clock edge drives its bit 0 on `ser_data`, with `ser_valid_n` = 0, in the cycle that follows that edge.
- R7: Inside an open packet with no byte available, `ser_valid_n` is 1, `ser_frame_n` stays 0 and `ser_data` is 0 until the next byte is accepted.
- R8: Asserting `rst_n` low sets the R1 idle state at once, without waiting for a clock. Any partly sent byte and any open packet are discarded and never resume.
- R9: If a new packet's first byte is offered while the previous packet's last bit is going out, its bit 0 follows in the very next cycle with `ser_frame_n` low and no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream byte present |
| in_data | input | 8 | Upstream payload byte |
| in_last | input | 1 | Byte is the final one of its packet |
| in_ready | output | 1 | Block takes the byte at this clock edge |
| ser_data | output | 1 | Serial data bit |
| ser_valid_n | output | 1 | Active-low data-bit qualifier |
| ser_frame_n | output | 1 | Active-low packet frame |

## Verification
Two events can land in the same cycle: the eighth bit of a byte going out and the next byte being accepted. When that byte is the packet's last, the frame also closes in that same clock, which can coincide with the next packet's byte being taken in. The bench provokes this with back-to-back bytes and back-to-back single-byte packets, offering the next byte long before the current one has finished shifting. A monitor rebuilds every byte and every frame end from the serial pins and compares them against the accepted stream. Directed checks confirm that the next bit and a fresh low frame appear in the very next cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_LOAD  = 2'd1,
    SH_SHIFT = 2'd2,
    SH_EMPTY = 2'd3
  } sh_op_e;
endpackage

// File: rtl/spf_shifter.sv
module spf_shifter #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  spf_pkg::sh_op_e      op,
  input  logic [W-1:0]         load_data,
  input  logic                 load_last,
  output logic                 full,
  output logic                 bit_out,
  output logic                 at_final_bit,
  output logic                 byte_is_last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;
  logic          last_q, last_d;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    last_d = last_q;
    case (op)
      spf_pkg::SH_LOAD: begin
        sreg_d = load_data;
        cnt_d  = '0;
        full_d = 1'b1;
        last_d = load_last;
      end
      spf_pkg::SH_SHIFT: begin
        sreg_d = sreg_q >> 1;
        cnt_d  = cnt_q + CW'(1);
      end
      spf_pkg::SH_EMPTY: begin
        cnt_d  = '0;
        full_d = 1'b0;
        last_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      last_q <= last_d;
    end
  end

  assign full         = full_q;
  assign bit_out      = full_q & sreg_q[0];
  assign at_final_bit = full_q & (cnt_q == CW'(W - 1));
  assign byte_is_last = last_q;
endmodule

// File: rtl/spf_frame_track.sv
module spf_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_last,
  output logic pkt_open
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (take) open_d = ~take_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign pkt_open = open_q;
endmodule

// File: rtl/serial_pkt_framer.sv
module serial_pkt_framer #(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ser_data,
  output logic              ser_valid_n,
  output logic              ser_frame_n
);
  import spf_pkg::*;

  logic [SYNC_LEN-1:0] rs_q;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[SYNC_LEN-1];

  logic   full, bit_out, at_final_bit, byte_is_last, pkt_open;
  logic   take;
  sh_op_e op;

  assign in_ready = ~full | at_final_bit;
  assign take     = in_valid & in_ready & rst_int_n;

  always_comb begin
    if (take)              op = SH_LOAD;
    else if (at_final_bit) op = SH_EMPTY;
    else if (full)         op = SH_SHIFT;
    else                   op = SH_HOLD;
  end

  spf_shifter #(.W(DATA_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .op           (op),
    .load_data    (in_data),
    .load_last    (in_last),
    .full         (full),
    .bit_out      (bit_out),
    .at_final_bit (at_final_bit),
    .byte_is_last (byte_is_last)
  );

  spf_frame_track u_frame (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .take      (take),
    .take_last (in_last),
    .pkt_open  (pkt_open)
  );

  assign ser_data    = bit_out;
  assign ser_valid_n = ~full;
  assign ser_frame_n = ~((full & ~(byte_is_last & at_final_bit)) | (~full & pkt_open));
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_data,
  input logic ser_valid_n,
  input logic ser_frame_n
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  logic [CW-1:0] qbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            qbits <= '0;
    else if (!ser_valid_n) qbits <= (qbits == CW'(DATA_W - 1)) ? '0 : qbits + CW'(1);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid_n |-> !ser_data);

  assert_frame_ends_on_eighth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid_n && ser_frame_n) |-> (qbits == CW'(DATA_W - 1)));

  assert_frame_rise_with_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_frame_n) |-> !ser_valid_n);

  assert_ready_low_midbyte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid_n && !in_ready) |=> !ser_valid_n);

  assert_accept_shows_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !ser_valid_n && qbits == CW'(DATA_W - 1)) |=> !ser_valid_n);

  assert_stall_holds_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_n && !ser_frame_n) |=> !ser_frame_n);
endmodule

bind serial_pkt_framer spf_checker #(.DATA_W(DATA_W)) u_spf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .ser_data    (ser_data),
  .ser_valid_n (ser_valid_n),
  .ser_frame_n (ser_frame_n)
);

// File: tb/tb_serial_pkt_framer.sv
module tb_serial_pkt_framer;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic       ser_data, ser_valid_n, ser_frame_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [8:0] exp_q [$];

  serial_pkt_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .ser_data(ser_data),
    .ser_valid_n(ser_valid_n), .ser_frame_n(ser_frame_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // monitor rebuilds bytes and frame ends from the serial pins
  int         bitidx;
  bit         in_frame;
  logic [7:0] rx;
  always @(negedge clk) begin
    if (!rst_n) begin
      bitidx   = 0;
      in_frame = 0;
    end else if (!ser_valid_n) begin
      chk(in_ready == (bitidx == 7), "R6 ready", in_ready, bitidx == 7);
      rx[bitidx] = ser_data;
      if (bitidx != 7) begin
        chk(ser_frame_n == 1'b0, "R4 early frame end", ser_frame_n, 0);
        bitidx++;
        in_frame = 1;
      end else begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected byte", rx, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rx == e[7:0], "R3 R5 byte", rx, e[7:0]);
          chk(ser_frame_n == e[8], "R4 frame at eighth bit", ser_frame_n, e[8]);
        end
        in_frame = !ser_frame_n;
        bitidx   = 0;
      end
    end else begin
      chk(bitidx == 0, "R3 partial byte", bitidx, 0);
      chk(ser_data == 1'b0, "R1 R7 data quiet", ser_data, 0);
      if (!ser_frame_n) chk(in_frame, "R7 stall inside packet", in_frame, 1);
      else              chk(!in_frame, "R2 frame dropped in stall", in_frame, 0);
    end
  end

  task automatic put_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back({l, d});
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    in_valid = 0; in_data = 0; in_last = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ser_valid_n && ser_frame_n && !ser_data, "R1 reset state",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b110);
    rst_n = 1;
    drain(4);

    // R6: accepted byte bit 0 visible next cycle
    put_byte(8'hA5, 1'b1);
    chk(!ser_valid_n && ser_data == 1'b1 && !ser_frame_n, "R6 first bit",
        {ser_valid_n, ser_data, ser_frame_n}, 3'b010);
    drain(12);
    chk(ser_valid_n && ser_frame_n && !ser_data, "R1 idle after packet",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b110);

    // R7: stall inside a packet
    put_byte(8'h3C, 1'b0);
    drain(12);
    chk(ser_valid_n && !ser_frame_n && !ser_data, "R7 stall",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b100);
    put_byte(8'hC3, 1'b1);
    drain(12);

    // R9: back-to-back single byte packets
    put_byte(8'h81, 1'b1);
    put_byte(8'h7E, 1'b1);
    chk(!ser_valid_n && !ser_frame_n && ser_data == 1'b0, "R9 next packet no gap",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b000);
    drain(12);

    // R8: reset in the middle of a byte
    put_byte(8'hF0, 1'b0);
    repeat (3) @(posedge clk);
    #2 rst_n = 0;
    #1;
    chk(ser_valid_n && ser_frame_n && !ser_data, "R8 async idle",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b110);
    exp_q.delete();
    drain(3);
    rst_n = 1;
    drain(5);
    chk(ser_valid_n && ser_frame_n, "R8 no resume", {ser_valid_n, ser_frame_n}, 2'b11);
    put_byte(8'h96, 1'b0);
    put_byte(8'h69, 1'b1);
    drain(12);

    // R5: random packets with random stalls
    for (int p = 0; p < 60; p++) begin
      int len;
      len = 1 + int'($urandom_range(0, 5));
      for (int b = 0; b < len; b++) begin
        int gap;
        gap = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 12)) : 0;
        drain(gap);
        put_byte(8'($urandom_range(0, 255)), b == len - 1);
      end
    end
    drain(20);
    chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
    chk(ser_valid_n && ser_frame_n && !ser_data, "R1 final idle",
        {ser_valid_n, ser_frame_n, ser_data}, 3'b110);
    finish_run();
  end
endmodule